// File: doc/BRIEF.md
# Run-time Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and active-area pixel coordinates for a raster display. Each line is divided into four intervals in a fixed order: sync, back porch, active, front porch. Each frame is divided in the same way, counted in lines. Software sets every interval length and both sync polarities through a small register port, so one instance can drive any video mode. The outputs feed a pixel source, which uses the coordinates to fetch data, and a DVI/HDMI-style transmitter. Serialization and link encoding are done elsewhere.

The register port is plain and single-cycle. A write takes effect at the next clock edge, and read data follows the address combinationally in the same cycle. The timing and polarity settings are copied into shadow registers, and the counters only use those copies. The copies are reloaded while the block is disabled and at the end of every frame, so software can reprogram a running display without tearing the current frame. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `vtg_top`

## Requirements
- R1: After reset the block is disabled, every register reads zero, both sync outputs are high (inactive with polarity 0), `de` is 0 and both coordinates are 0.
- R2: Register map (byte address on `reg_addr`). 0x04: bit 0 is the enable, other bits store nothing. 0x20: sync widths. 0x24: back porches. 0x28: active sizes. 0x2C: front porches. Each of these four holds the vertical value in bits 31:16 and the horizontal value in bits 15:0. 0x30: horizontal polarity in bit 0 and vertical polarity in bit 16, all other bits read 0. Any other address reads 0 and ignores writes. `reg_rdata` shows the addressed register in the same cycle.
- R3: While enabled, the horizontal position runs from 0 to HS+HB+HA+HF-1 and then wraps to 0. Horizontal sync is asserted for positions below HS. The active interval covers positions HS+HB to HS+HB+HA-1.
- R4: The vertical position advances by one on the last cycle of each line and wraps after VS+VB+VA+VF lines. Vertical sync is asserted on lines below VS.
- R5: A polarity bit of 1 makes that sync output high while asserted. A bit of 0 makes it low while asserted. The deasserted level is the inverse.
- R6: `de` is 1 only when both axes are in their active interval. `pix_x` and `pix_y` count from 0 at the first active pixel and line, and are 0 whenever `de` is 0.
- R7: While the enable bit is 0, both positions are held at 0, both syncs sit at their deasserted level, and `de` is 0. In the first cycle after the enable bit is written to 1, the outputs show position (0,0), which is the start of sync.
- R8: Writes to the timing or polarity registers while enabled are applied only from the first cycle of the next frame. While disabled they are applied at once.
- R9: Any porch or sync interval may be zero, and the intervals that remain keep their order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | Data enable (active area) |
| pix_x | output | 16 | Active-area column |
| pix_y | output | 16 | Active-area row |

## Verification
The generator runs against a behavioural reference model, and the two are compared every cycle across several geometries. An asymmetric mode with distinct interval lengths shows whether the intervals come in the right order and at the right boundaries. A mode with a zero front porch tests the handling of empty intervals. A mid-frame rewrite of the active sizes and polarities tells a frame-boundary update apart from an immediate one. Disable and re-enable sequences, checked against the polarity in force, show whether the block idles and restarts at the start of sync.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned WORD_W  = 32;

  localparam logic [5:0] ADR_CTRL  = 6'h04;
  localparam logic [5:0] ADR_SYNC  = 6'h20;
  localparam logic [5:0] ADR_BACK  = 6'h24;
  localparam logic [5:0] ADR_ACT   = 6'h28;
  localparam logic [5:0] ADR_FRONT = 6'h2C;
  localparam logic [5:0] ADR_POL   = 6'h30;

  typedef struct packed {
    logic [FIELD_W-1:0] sync_len;
    logic [FIELD_W-1:0] back_len;
    logic [FIELD_W-1:0] act_len;
    logic [FIELD_W-1:0] front_len;
  } axis_cfg_t;

  typedef struct packed {
    axis_cfg_t h;
    axis_cfg_t v;
    logic      hpol;
    logic      vpol;
  } tim_cfg_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              en,
  output tim_cfg_t          cfg
);
  localparam int unsigned HI = FIELD_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      cfg <= '0;
    end else if (we) begin
      case (6'(addr))
        ADR_CTRL:  en <= wdata[0];
        ADR_SYNC:  begin cfg.v.sync_len  <= wdata[WORD_W-1:HI]; cfg.h.sync_len  <= wdata[HI-1:0]; end
        ADR_BACK:  begin cfg.v.back_len  <= wdata[WORD_W-1:HI]; cfg.h.back_len  <= wdata[HI-1:0]; end
        ADR_ACT:   begin cfg.v.act_len   <= wdata[WORD_W-1:HI]; cfg.h.act_len   <= wdata[HI-1:0]; end
        ADR_FRONT: begin cfg.v.front_len <= wdata[WORD_W-1:HI]; cfg.h.front_len <= wdata[HI-1:0]; end
        ADR_POL:   begin cfg.vpol <= wdata[HI]; cfg.hpol <= wdata[0]; end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (6'(addr))
      ADR_CTRL:  rdata[0] = en;
      ADR_SYNC:  rdata = {cfg.v.sync_len, cfg.h.sync_len};
      ADR_BACK:  rdata = {cfg.v.back_len, cfg.h.back_len};
      ADR_ACT:   rdata = {cfg.v.act_len, cfg.h.act_len};
      ADR_FRONT: rdata = {cfg.v.front_len, cfg.h.front_len};
      ADR_POL:   begin rdata[HI] = cfg.vpol; rdata[0] = cfg.hpol; end
      default:   rdata = '0;
    endcase
  end

  // R2: the enable bit follows bit 0 of a write to the control address
  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && 6'(addr) == ADR_CTRL) |=> (en == $past(wdata[0])));
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int unsigned FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  axis_cfg_t     cfg,
  output logic          wrap,
  output logic          sync_on,
  output logic          act_on,
  output logic [FW-1:0] coord
);
  localparam int unsigned PW = FW + 2;

  logic [PW-1:0] pos, total, act_lo, act_hi;
  logic          last;

  assign act_lo = PW'(cfg.sync_len) + PW'(cfg.back_len);
  assign act_hi = act_lo + PW'(cfg.act_len);
  assign total  = act_hi + PW'(cfg.front_len);
  assign last   = (pos + PW'(1)) >= total;
  assign wrap   = run && step && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pos <= '0;
    else if (!run)       pos <= '0;
    else if (step) begin
      if (last)          pos <= '0;
      else               pos <= pos + PW'(1);
    end
  end

  assign sync_on = pos < PW'(cfg.sync_len);
  assign act_on  = (pos >= act_lo) && (pos < act_hi);
  assign coord   = act_on ? FW'(pos - act_lo) : '0;

  // R3: a step inside the interval advances by exactly one
  a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && !last) |=> (pos == $past(pos) + PW'(1)));
  // R3: the last position of the axis is followed by position zero
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step && last) |=> (pos == '0));
  // R7: a disabled axis sits at zero
  a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos == '0));
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned FW = FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [FW-1:0]     pix_x,
  output logic [FW-1:0]     pix_y
);
  localparam int unsigned NAX = 2;

  logic      en;
  tim_cfg_t  live_cfg, shd_cfg;
  axis_cfg_t acfg [NAX];
  logic [NAX-1:0] step, wrap, sync_on, act_on;
  logic [FW-1:0]  coord [NAX];
  logic           frame_end;

  vtg_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .en(en), .cfg(live_cfg)
  );

  // shadow copy follows the live registers while idle and at frame end
  assign frame_end = wrap[NAX-1];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                shd_cfg <= '0;
    else if (!en || frame_end) shd_cfg <= live_cfg;
  end

  always_comb begin
    acfg[0] = shd_cfg.h;
    acfg[1] = shd_cfg.v;
    step[0] = 1'b1;
    step[1] = wrap[0];
  end

  for (genvar g = 0; g < NAX; g++) begin : g_axis
    vtg_axis #(.FW(FW)) u_axis (
      .clk(clk), .rst_n(rst_n), .run(en), .step(step[g]), .cfg(acfg[g]),
      .wrap(wrap[g]), .sync_on(sync_on[g]), .act_on(act_on[g]), .coord(coord[g])
    );
  end

  assign hsync = en ? (sync_on[0] ~^ shd_cfg.hpol) : ~shd_cfg.hpol;
  assign vsync = en ? (sync_on[1] ~^ shd_cfg.vpol) : ~shd_cfg.vpol;
  assign de    = en && act_on[0] && act_on[1];
  assign pix_x = de ? coord[0] : '0;
  assign pix_y = de ? coord[1] : '0;

  // R8: the settings in use do not move while a frame is running
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_end) |=> $stable(shd_cfg));
  // R4: the vertical axis only wraps together with a horizontal wrap
  a_r4_v_on_h: assert property (@(posedge clk) disable iff (!rst_n)
    wrap[1] |-> wrap[0]);
endmodule

// File: tb/vtg_top_tb.sv
`timescale 1ns/1ps
module vtg_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        hsync, vsync, de;
  logic [15:0] px, py;

  int tests = 0, fails = 0;
  bit cmp_on = 0;

  // reference model state
  logic [31:0] l_en, l_sync, l_back, l_act, l_front, l_pol;
  logic [31:0] s_sync, s_back, s_act, s_front, s_pol;
  int hc, vc;

  always #2.5 clk = ~clk;

  vtg_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .hsync(hsync), .vsync(vsync), .de(de), .pix_x(px), .pix_y(py)
  );

  function automatic int fld(logic [31:0] w, bit vert);
    return vert ? int'(w[31:16]) : int'(w[15:0]);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_en = 0; l_sync = 0; l_back = 0; l_act = 0; l_front = 0; l_pol = 0;
      s_sync = 0; s_back = 0; s_act = 0; s_front = 0; s_pol = 0;
      hc = 0; vc = 0;
    end else begin
      int ht, vt;
      bit fe;
      ht = fld(s_sync,0) + fld(s_back,0) + fld(s_act,0) + fld(s_front,0);
      vt = fld(s_sync,1) + fld(s_back,1) + fld(s_act,1) + fld(s_front,1);
      fe = 0;
      if (l_en[0] == 1'b0) begin hc = 0; vc = 0; end
      else if (hc + 1 >= ht) begin
        hc = 0;
        if (vc + 1 >= vt) begin vc = 0; fe = 1; end else vc++;
      end else hc++;
      if (l_en[0] == 1'b0 || fe) begin
        s_sync = l_sync; s_back = l_back; s_act = l_act; s_front = l_front; s_pol = l_pol;
      end
      if (we) case (addr)
        6'h04: l_en = {31'b0, wdata[0]};
        6'h20: l_sync = wdata;
        6'h24: l_back = wdata;
        6'h28: l_act = wdata;
        6'h2C: l_front = wdata;
        6'h30: l_pol = wdata & 32'h0001_0001;
        default: ;
      endcase
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) if (cmp_on && rst_n) begin
    bit e, hon, von, hact, vact, hp, vp, eh, ev, ede;
    int hs, hb, ha, vs, vb, va, ex, ey;
    e = l_en[0];
    hs = fld(s_sync,0); hb = fld(s_back,0); ha = fld(s_act,0);
    vs = fld(s_sync,1); vb = fld(s_back,1); va = fld(s_act,1);
    hp = s_pol[0]; vp = s_pol[16];
    hon = hc < hs; von = vc < vs;
    hact = (hc >= hs + hb) && (hc < hs + hb + ha);
    vact = (vc >= vs + vb) && (vc < vs + vb + va);
    eh = e ? (hp ? hon : !hon) : !hp;
    ev = e ? (vp ? von : !von) : !vp;
    ede = e && hact && vact;
    ex = ede ? hc - (hs + hb) : 0;
    ey = ede ? vc - (vs + vb) : 0;
    chk(hsync == eh, "R3 R5 R7 R8 R9 hsync", hsync, eh);
    chk(vsync == ev, "R4 R5 R7 R8 vsync", vsync, ev);
    chk(de == ede, "R6 R8 R9 de", de, ede);
    chk(int'(px) == ex, "R6 R3 pix_x", px, ex);
    chk(int'(py) == ey, "R6 R4 pix_y", py, ey);
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
    @(negedge clk); addr = a; #1;
    chk(rdata == exp, tag, rdata, exp);
    addr = '0;
  endtask

  task automatic run_count(int n, output int dcnt);
    dcnt = 0;
    for (int i = 0; i < n; i++) begin
      if (i != 0) @(negedge clk);
      #1 if (de) dcnt++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(hsync == 1'b1, "R1 hsync", hsync, 1);
    chk(vsync == 1'b1, "R1 vsync", vsync, 1);
    chk(de == 1'b0, "R1 de", de, 0);
    rst_n = 1;
    cmp_on = 1;
    rd(6'h04, 0, "R1 ctrl");
    rd(6'h28, 0, "R1 active");
    rd(6'h30, 0, "R1 pol");
    // R2 register port
    wr(6'h20, 32'h0001_0002);
    wr(6'h24, 32'h0002_0003);
    wr(6'h28, 32'h0003_0004);
    wr(6'h2C, 32'h0001_0001);
    wr(6'h30, 32'hFFFF_FFFF);
    rd(6'h20, 32'h0001_0002, "R2 sync");
    rd(6'h24, 32'h0002_0003, "R2 back");
    rd(6'h2C, 32'h0001_0001, "R2 front");
    rd(6'h30, 32'h0001_0001, "R2 pol reserved");
    wr(6'h18, 32'h1234_5678);
    rd(6'h18, 0, "R2 unmapped");
    wr(6'h04, 32'hFFFF_FFFE);
    rd(6'h04, 0, "R2 ctrl bit0");
    chk(hsync == 1'b0, "R7 idle hsync pol1", hsync, 0);
    wr(6'h30, 32'h0);
    // R7 restart, R3 R4 R6 two frames of 10x7
    wr(6'h04, 1);
    chk(hsync == 1'b0 && vsync == 1'b0, "R7 restart in sync", {hsync, vsync}, 0);
    run_count(140, d);
    chk(d == 24, "R6 de count two frames", d, 24);
    // R8 mid-frame change of active sizes and polarity
    repeat (20) @(negedge clk);
    wr(6'h28, 32'h0002_0002);
    wr(6'h30, 32'h0001_0001);
    repeat (200) @(negedge clk);
    // R9 zero horizontal front porch and zero vertical back porch
    wr(6'h2C, 32'h0001_0000);
    wr(6'h24, 32'h0000_0003);
    repeat (200) @(negedge clk);
    // R7 disable mid-frame
    repeat (7) @(negedge clk);
    wr(6'h04, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      chk(de == 0 && px == 0 && py == 0, "R7 idle outputs", de, 0);
    end
    wr(6'h30, 32'h0);
    @(negedge clk); #1;
    chk(hsync == 1 && vsync == 1, "R8 idle pol applies at once", {hsync, vsync}, 3);
    wr(6'h04, 1);
    repeat (150) @(negedge clk);
    cmp_on = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule